// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Walk-on-Miss

This block translates virtual addresses to physical addresses for one requester. Translations live in a small fully associative array. Each slot holds an aligned virtual base and an aligned physical base. It also holds a page-size code (4 KB, 2 MB or 4 MB), so pages of all three sizes share one array. Each slot also carries the attribute bits: writable, user-accessible, no-execute, global, uncacheable and page-attribute. On a hit the block merges the entry's physical base with the offset bits below that entry's page size. It also runs protection checks against the access type and answers one cycle after acceptance.

On a miss the request becomes a delayed response. The block raises a walk request toward an external page-table walker and holds the request. It stalls new requests until the walker reports back. After a successful walk, the returned mapping is installed and the lookup is rerun internally. The rerun answers from the array with no further walker traffic, and it can still raise a protection fault. A fault reported by the walker goes straight back to the requester, unchanged. Replacement prefers a free slot and otherwise evicts the least recently used entry. Software-side maintenance can flush the whole array or remove the single page that covers a given address.

Top module: `tlb_walk_xlate`

## Requirements
- R1: A request accepted (req_valid and req_ready high at a clock edge) that hits produces rsp_valid in the next cycle. That response has rsp_status 2'b00, rsp_paddr equal to the entry's physical base ORed with the request address bits below the entry's page size, and {rsp_global, rsp_uncache, rsp_pat} taken from the entry.
- R2: Page-size code 0 is 4 KB (12 offset bits), code 1 is 2 MB (21 bits) and code 2 is 4 MB (22 bits). An entry matches any address inside its own page, and entries of different sizes coexist.
- R3: An accepted request that misses raises walk_req in the next cycle, with walk_vaddr equal to the request address. req_ready stays low and no response appears until the walk finishes.
- R4: If walk_done is high in cycle c with walk_fault low, the returned mapping is installed. The rerun lookup then gives rsp_valid in cycle c+2, and later requests to that page hit without a walk.
- R5: If walk_done is high in cycle c with walk_fault high, the response appears in cycle c+1 with rsp_status 2'b01 and rsp_fcode equal to walk_fcode. Nothing is installed, so a repeat request walks again.
- R6: A protection violation gives rsp_status 2'b10 and rsp_paddr zero. rsp_fcode bit 0 flags a write to a read-only page, bit 1 a user access to a supervisor page, and bit 2 an execute from a no-execute page. The check applies to hits and to the rerun after a walk.
- R7: A newly installed entry goes to the lowest-numbered free slot if one exists, and otherwise replaces the least recently used entry. The new entry becomes most recently used.
- R8: A hit with req_touch high makes the entry most recently used. A hit with req_touch low leaves the recency order unchanged.
- R9: A cycle with inval_all high removes every entry, so later requests miss.
- R10: A cycle with demap_en high removes only the entry whose page contains demap_vaddr, judged by that entry's page size. All other entries remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_exec | input | 1 | Access is an instruction fetch |
| req_user | input | 1 | Access is at user privilege |
| req_touch | input | 1 | Promote the hit entry to most recently used |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_status | output | 2 | 0 ok, 1 walk fault, 2 protection fault |
| rsp_fcode | output | 4 | Fault code (walker code or violation bits) |
| rsp_paddr | output | 40 | Physical address |
| rsp_global | output | 1 | Entry global bit |
| rsp_uncache | output | 1 | Entry uncacheable bit |
| rsp_pat | output | 1 | Entry page-attribute bit |
| walk_req | output | 1 | Walk requested, held until walk_done |
| walk_vaddr | output | 32 | Address to walk |
| walk_done | input | 1 | Walker finished |
| walk_fault | input | 1 | Walk ended in a fault |
| walk_fcode | input | 4 | Walker fault code |
| walk_pbase | input | 40 | Physical base of the found page |
| walk_size | input | 2 | Page-size code of the found page |
| walk_wr | input | 1 | Page writable |
| walk_usr | input | 1 | Page user-accessible |
| walk_nx | input | 1 | Page no-execute |
| walk_glb | input | 1 | Page global |
| walk_uc | input | 1 | Page uncacheable |
| walk_pat | input | 1 | Page attribute bit |
| inval_all | input | 1 | Remove all entries |
| demap_en | input | 1 | Remove the page containing demap_vaddr |
| demap_vaddr | input | 32 | Address for demap |

## Verification
A hit answers in the cycle after acceptance. A walk request appears in that same cycle when the lookup misses. A walker fault answers in the cycle after walk_done, and a successful walk answers two cycles after walk_done because of the internal rerun. The bench drives every input on the falling edge, so it samples each result half a cycle after the edge that registers it. For every transaction it checks that the response is present in exactly the due cycle and absent in the cycles before. Replacement and promotion order are observed only at the ports, through which later requests hit and which ones raise a walk.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W   = 32;
  localparam int PA_W   = 40;
  localparam int FC_W   = 4;
  localparam int OFF_4K = 12;
  localparam int OFF_2M = 21;
  localparam int OFF_4M = 22;

  typedef enum logic [1:0] {
    PG_4K = 2'd0,
    PG_2M = 2'd1,
    PG_4M = 2'd2
  } pg_size_e;

  typedef enum logic [1:0] {
    RS_OK   = 2'd0,
    RS_WALK = 2'd1,
    RS_PROT = 2'd2
  } rsp_stat_e;

  typedef enum logic [1:0] {
    XS_IDLE   = 2'd0,
    XS_WALK   = 2'd1,
    XS_RELOOK = 2'd2
  } xlate_st_e;

  typedef struct packed {
    logic [VA_W-1:0] vbase;
    logic [PA_W-1:0] pbase;
    pg_size_e        size;
    logic            wr;
    logic            usr;
    logic            nx;
    logic            glb;
    logic            uc;
    logic            pat;
  } tlb_ent_t;

  // Mask of the offset bits that lie below a page of the given size.
  function automatic logic [VA_W-1:0] off_mask(input pg_size_e sz);
    int unsigned nb;
    case (sz)
      PG_2M:   nb = OFF_2M;
      PG_4M:   nb = OFF_4M;
      default: nb = OFF_4K;
    endcase
    return (VA_W'(1) << nb) - VA_W'(1);
  endfunction
endpackage

// File: rtl/tlb_array.sv
module tlb_array
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [VA_W-1:0]        lk_vaddr,
  output logic                   lk_hit,
  output logic [IDX_W-1:0]       lk_idx,
  output tlb_ent_t               lk_ent,
  output logic [NUM_ENTRIES-1:0] valid_vec,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  tlb_ent_t               wr_ent,
  input  logic                   inval_all,
  input  logic                   dmp_en,
  input  logic [VA_W-1:0]        dmp_vaddr
);
  logic [NUM_ENTRIES-1:0] valid_q, valid_d;
  logic [NUM_ENTRIES-1:0] lk_match, dmp_match;
  logic [NUM_ENTRIES-1:0] wr_vec;
  tlb_ent_t               ent_q [NUM_ENTRIES];

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_slot
    logic [VA_W-1:0] pmask;
    assign pmask        = ~off_mask(ent_q[i].size);
    assign lk_match[i]  = valid_q[i] && ((lk_vaddr & pmask) == ent_q[i].vbase);
    assign dmp_match[i] = valid_q[i] && ((dmp_vaddr & pmask) == ent_q[i].vbase);
    assign wr_vec[i]    = wr_en && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (wr_vec[i]) ent_q[i] <= wr_ent;
    end
  end

  // Flushes act first, so a slot written at the same edge survives.
  always_comb begin
    valid_d = valid_q;
    if (inval_all)   valid_d = '0;
    else if (dmp_en) valid_d = valid_q & ~dmp_match;
    valid_d = valid_d | wr_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_comb begin
    lk_idx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (lk_match[i]) lk_idx = IDX_W'(i);
    end
  end

  assign lk_hit    = |lk_match;
  assign lk_ent    = ent_q[lk_idx];
  assign valid_vec = valid_q;

  // R2: pages never overlap, so at most one slot claims an address
  a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  // R9: after a flush only a slot written at that edge can be valid
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    inval_all |=> ((valid_q & ~$past(wr_vec)) == '0));
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] victim_idx
);
  logic [IDX_W-1:0]       age_q [NUM_ENTRIES];
  logic [IDX_W-1:0]       age_d [NUM_ENTRIES];
  logic [IDX_W-1:0]       ref_age;
  logic [NUM_ENTRIES-1:0] oldest_vec;

  assign ref_age = age_q[touch_idx];

  // Touched slot becomes age 0; every slot younger than it ages by one.
  always_comb begin
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      age_d[i] = age_q[i];
      if (touch_en) begin
        if (touch_idx == IDX_W'(i))  age_d[i] = '0;
        else if (age_q[i] < ref_age) age_d[i] = age_q[i] + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENTRIES; i++) age_q[i] <= IDX_W'(i);
    end else begin
      for (int i = 0; i < NUM_ENTRIES; i++) age_q[i] <= age_d[i];
    end
  end

  always_comb begin
    victim_idx = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      oldest_vec[i] = (age_q[i] == IDX_W'(NUM_ENTRIES - 1));
      if (oldest_vec[i]) victim_idx = IDX_W'(i);
    end
  end

  // R7: ages stay a permutation, so exactly one slot is the oldest
  a_r7_one_victim: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_vec) == 1);
endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
  import tlb_pkg::*;
(
  input  logic [PA_W-1:0] ent_pbase,
  input  pg_size_e        ent_size,
  input  logic            ent_wr,
  input  logic            ent_usr,
  input  logic            ent_nx,
  input  logic [VA_W-1:0] vaddr,
  input  logic            acc_wr,
  input  logic            acc_ex,
  input  logic            acc_usr,
  output logic [PA_W-1:0] paddr,
  output logic [FC_W-1:0] viol
);
  assign paddr = ent_pbase | PA_W'(vaddr & off_mask(ent_size));
  assign viol  = {1'b0, acc_ex & ent_nx, acc_usr & ~ent_usr, acc_wr & ~ent_wr};
endmodule

// File: rtl/tlb_walk_xlate.sv
module tlb_walk_xlate
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [31:0]     req_vaddr,
  input  logic            req_write,
  input  logic            req_exec,
  input  logic            req_user,
  input  logic            req_touch,
  output logic            rsp_valid,
  output logic [1:0]      rsp_status,
  output logic [3:0]      rsp_fcode,
  output logic [39:0]     rsp_paddr,
  output logic            rsp_global,
  output logic            rsp_uncache,
  output logic            rsp_pat,
  output logic            walk_req,
  output logic [31:0]     walk_vaddr,
  input  logic            walk_done,
  input  logic            walk_fault,
  input  logic [3:0]      walk_fcode,
  input  logic [39:0]     walk_pbase,
  input  logic [1:0]      walk_size,
  input  logic            walk_wr,
  input  logic            walk_usr,
  input  logic            walk_nx,
  input  logic            walk_glb,
  input  logic            walk_uc,
  input  logic            walk_pat,
  input  logic            inval_all,
  input  logic            demap_en,
  input  logic [31:0]     demap_vaddr
);
  localparam int IDX_W = $clog2(NUM_ENTRIES);

  xlate_st_e              state_q, state_d;
  logic [VA_W-1:0]        hold_va;
  logic                   hold_w, hold_x, hold_u;
  logic                   acc, relook, fill;
  logic [VA_W-1:0]        lk_va;
  logic                   lk_w, lk_x, lk_u;
  logic                   lk_hit;
  logic [IDX_W-1:0]       lk_idx;
  tlb_ent_t               lk_ent;
  logic [NUM_ENTRIES-1:0] valid_vec;
  logic [PA_W-1:0]        mrg_pa;
  logic [FC_W-1:0]        viol;
  logic [IDX_W-1:0]       victim_idx, free_idx, wr_idx;
  logic                   has_free;
  tlb_ent_t               wr_ent;
  pg_size_e               fill_sz;
  logic                   touch_en;
  logic [IDX_W-1:0]       touch_idx;

  logic                   rsp_valid_d;
  rsp_stat_e              rsp_st_d;
  logic [FC_W-1:0]        rsp_fc_d;
  logic [PA_W-1:0]        rsp_pa_d;
  logic [2:0]             rsp_attr_d, rsp_attr_q;
  rsp_stat_e              rsp_st_q;

  assign req_ready = (state_q == XS_IDLE);
  assign acc       = req_valid && req_ready;
  assign relook    = (state_q == XS_RELOOK);
  assign fill      = (state_q == XS_WALK) && walk_done && !walk_fault;

  // The rerun uses the held request; otherwise the live request looks up.
  assign lk_va = relook ? hold_va : req_vaddr;
  assign lk_w  = relook ? hold_w  : req_write;
  assign lk_x  = relook ? hold_x  : req_exec;
  assign lk_u  = relook ? hold_u  : req_user;

  always_ff @(posedge clk) begin
    if (acc) begin
      hold_va <= req_vaddr;
      hold_w  <= req_write;
      hold_x  <= req_exec;
      hold_u  <= req_user;
    end
  end

  tlb_array #(.NUM_ENTRIES(NUM_ENTRIES)) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_vaddr  (lk_va),
    .lk_hit    (lk_hit),
    .lk_idx    (lk_idx),
    .lk_ent    (lk_ent),
    .valid_vec (valid_vec),
    .wr_en     (fill),
    .wr_idx    (wr_idx),
    .wr_ent    (wr_ent),
    .inval_all (inval_all),
    .dmp_en    (demap_en),
    .dmp_vaddr (demap_vaddr)
  );

  tlb_perm u_perm (
    .ent_pbase (lk_ent.pbase),
    .ent_size  (lk_ent.size),
    .ent_wr    (lk_ent.wr),
    .ent_usr   (lk_ent.usr),
    .ent_nx    (lk_ent.nx),
    .vaddr     (lk_va),
    .acc_wr    (lk_w),
    .acc_ex    (lk_x),
    .acc_usr   (lk_u),
    .paddr     (mrg_pa),
    .viol      (viol)
  );

  assign touch_en  = fill || (acc && lk_hit && req_touch);
  assign touch_idx = fill ? wr_idx : lk_idx;

  tlb_lru #(.NUM_ENTRIES(NUM_ENTRIES)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch_en   (touch_en),
    .touch_idx  (touch_idx),
    .victim_idx (victim_idx)
  );

  // Lowest-numbered free slot.
  always_comb begin
    free_idx = '0;
    has_free = 1'b0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_idx = IDX_W'(i);
        has_free = 1'b1;
      end
    end
  end

  assign wr_idx  = has_free ? free_idx : victim_idx;
  assign fill_sz = pg_size_e'(walk_size);

  always_comb begin
    wr_ent       = '0;
    wr_ent.vbase = hold_va & ~off_mask(fill_sz);
    wr_ent.pbase = walk_pbase & ~PA_W'(off_mask(fill_sz));
    wr_ent.size  = fill_sz;
    wr_ent.wr    = walk_wr;
    wr_ent.usr   = walk_usr;
    wr_ent.nx    = walk_nx;
    wr_ent.glb   = walk_glb;
    wr_ent.uc    = walk_uc;
    wr_ent.pat   = walk_pat;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      XS_IDLE:   if (acc && !lk_hit) state_d = XS_WALK;
      XS_WALK:   if (walk_done) state_d = walk_fault ? XS_IDLE : XS_RELOOK;
      XS_RELOOK: state_d = XS_IDLE;
      default:   state_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= XS_IDLE;
    else        state_q <= state_d;
  end

  // Response next-state: a hit or rerun reports paging results, a walk
  // fault passes the walker's code through untouched.
  always_comb begin
    rsp_valid_d = 1'b0;
    rsp_st_d    = RS_OK;
    rsp_fc_d    = '0;
    rsp_pa_d    = '0;
    rsp_attr_d  = {lk_ent.glb, lk_ent.uc, lk_ent.pat};
    if ((state_q == XS_WALK) && walk_done && walk_fault) begin
      rsp_valid_d = 1'b1;
      rsp_st_d    = RS_WALK;
      rsp_fc_d    = walk_fcode;
    end else if (relook || (acc && lk_hit)) begin
      rsp_valid_d = 1'b1;
      if (viol != '0) begin
        rsp_st_d = RS_PROT;
        rsp_fc_d = viol;
      end else begin
        rsp_pa_d = mrg_pa;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= rsp_valid_d;
  end

  always_ff @(posedge clk) begin
    if (rsp_valid_d) begin
      rsp_st_q   <= rsp_st_d;
      rsp_fcode  <= rsp_fc_d;
      rsp_paddr  <= rsp_pa_d;
      rsp_attr_q <= rsp_attr_d;
    end
  end

  assign rsp_status  = rsp_st_q;
  assign rsp_global  = rsp_attr_q[2];
  assign rsp_uncache = rsp_attr_q[1];
  assign rsp_pat     = rsp_attr_q[0];
  assign walk_req    = (state_q == XS_WALK);
  assign walk_vaddr  = hold_va;

  // R1: an accepted hit is answered on the following cycle
  a_r1_hit_answers: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && lk_hit) |=> rsp_valid);

  // R3: a miss asks the walker for the same address on the next cycle
  a_r3_miss_walks: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !lk_hit) |=> (walk_req && !req_ready && walk_vaddr == $past(req_vaddr)));

  // R4: the rerun after a successful fill always finds the new entry
  a_r4_rerun_hits: assert property (@(posedge clk) disable iff (!rst_n)
    relook |-> lk_hit);

  // R5: walker faults reach the requester with their code intact
  a_r5_fault_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == XS_WALK) && walk_done && walk_fault) |=>
      (rsp_valid && rsp_status == RS_WALK && rsp_fcode == $past(walk_fcode)));
endmodule

// File: tb/tb_tlb_walk_xlate.sv
module tb_tlb_walk_xlate;
  logic        clk, rst_n;
  logic        req_valid, req_ready, req_write, req_exec, req_user, req_touch;
  logic [31:0] req_vaddr;
  logic        rsp_valid, rsp_global, rsp_uncache, rsp_pat;
  logic [1:0]  rsp_status;
  logic [3:0]  rsp_fcode;
  logic [39:0] rsp_paddr;
  logic        walk_req, walk_done, walk_fault;
  logic [31:0] walk_vaddr;
  logic [3:0]  walk_fcode;
  logic [39:0] walk_pbase;
  logic [1:0]  walk_size;
  logic        walk_wr, walk_usr, walk_nx, walk_glb, walk_uc, walk_pat;
  logic        inval_all, demap_en;
  logic [31:0] demap_vaddr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  tlb_walk_xlate dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_exec(req_exec), .req_user(req_user),
    .req_touch(req_touch),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_fcode(rsp_fcode),
    .rsp_paddr(rsp_paddr), .rsp_global(rsp_global), .rsp_uncache(rsp_uncache),
    .rsp_pat(rsp_pat),
    .walk_req(walk_req), .walk_vaddr(walk_vaddr), .walk_done(walk_done),
    .walk_fault(walk_fault), .walk_fcode(walk_fcode), .walk_pbase(walk_pbase),
    .walk_size(walk_size), .walk_wr(walk_wr), .walk_usr(walk_usr),
    .walk_nx(walk_nx), .walk_glb(walk_glb), .walk_uc(walk_uc),
    .walk_pat(walk_pat),
    .inval_all(inval_all), .demap_en(demap_en), .demap_vaddr(demap_vaddr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic [31:0] va;
    logic        w, x, u;
    logic [1:0]  st;
    logic [3:0]  fc;
    logic [39:0] pa;
    logic [2:0]  attr;
  } vec_t;

  // All rows hit entries installed by the priming walks.
  localparam vec_t VT [8] = '{
    '{32'h0070_0000, 1'b0, 1'b1, 1'b0, 2'd0, 4'h0, 40'h00_C030_0000, 3'b000},
    '{32'h0041_2345, 1'b1, 1'b0, 1'b1, 2'd0, 4'h0, 40'h00_C001_2345, 3'b000},
    '{32'h0081_0ABC, 1'b1, 1'b0, 1'b1, 2'd2, 4'h1, 40'h0,            3'b000},
    '{32'h009F_FFFF, 1'b0, 1'b1, 1'b1, 2'd2, 4'h4, 40'h0,            3'b000},
    '{32'h1234_5FFF, 1'b0, 1'b0, 1'b0, 2'd0, 4'h0, 40'h50_0234_5FFF, 3'b100},
    '{32'h1234_5000, 1'b0, 1'b1, 1'b1, 2'd2, 4'h2, 40'h0,            3'b000},
    '{32'h0080_0000, 1'b1, 1'b1, 1'b0, 2'd2, 4'h5, 40'h0,            3'b000},
    '{32'h007F_FFFF, 1'b0, 1'b0, 1'b1, 2'd0, 4'h0, 40'h00_C03F_FFFF, 3'b000}
  };

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // Page-table model used by the bench's walker.
  task automatic drive_walk(input logic [31:0] va, output bit flt);
    walk_fault = 1'b0; walk_fcode = 4'h0; walk_pbase = '0; walk_size = 2'd0;
    walk_wr = 1'b0; walk_usr = 1'b0; walk_nx = 1'b0;
    walk_glb = 1'b0; walk_uc = 1'b0; walk_pat = 1'b0;
    if (va[31:22] == 10'h001) begin
      walk_pbase = 40'h00_C000_0000; walk_size = 2'd2;
      walk_wr = 1'b1; walk_usr = 1'b1;
    end else if (va[31:21] == 11'h004) begin
      walk_pbase = 40'h01_0020_0000; walk_size = 2'd1;
      walk_usr = 1'b1; walk_nx = 1'b1; walk_uc = 1'b1; walk_pat = 1'b1;
    end else if (va[31:28] == 4'h1) begin
      walk_pbase = 40'h50_0000_0000 | {12'h0, va[27:12], 12'h000};
      walk_wr = 1'b1; walk_glb = 1'b1;
    end else if (va[31:28] == 4'hF) begin
      walk_fault = 1'b1; walk_fcode = va[15:12];
    end else begin
      walk_fault = 1'b1; walk_fcode = 4'hE;
    end
    flt = walk_fault;
  endtask

  // One translation; inputs change on falling edges only.
  task automatic xlate(input logic [31:0] va, input bit w, x, u, t,
                       output bit walked);
    bit flt;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = w; req_exec = x;
    req_user = u; req_touch = t;
    @(negedge clk);
    req_valid = 1'b0;
    walked = 1'b0;
    if (rsp_valid) return;
    walked = 1'b1;
    chk(walk_req === 1'b1, "R3", "walk_req after miss", 64'(walk_req), 64'd1);
    chk(walk_vaddr === va, "R3", "walk_vaddr", 64'(walk_vaddr), 64'(va));
    repeat (2) begin
      chk(req_ready === 1'b0 && rsp_valid === 1'b0, "R3", "stall during walk",
          64'({req_ready, rsp_valid}), 64'd0);
      @(negedge clk);
    end
    drive_walk(va, flt);
    walk_done = 1'b1;
    @(negedge clk);
    walk_done = 1'b0;
    if (flt) begin
      chk(rsp_valid === 1'b1, "R5", "fault response timing", 64'(rsp_valid), 64'd1);
    end else begin
      chk(rsp_valid === 1'b0, "R4", "no early response", 64'(rsp_valid), 64'd0);
      @(negedge clk);
      chk(rsp_valid === 1'b1, "R4", "rerun response timing", 64'(rsp_valid), 64'd1);
    end
  endtask

  task automatic expect_rsp(input string rq, input logic [1:0] st,
                            input logic [3:0] fc, input logic [39:0] pa,
                            input logic [2:0] attr, input bit chk_attr);
    chk(rsp_status === st, rq, "status", 64'(rsp_status), 64'(st));
    chk(rsp_fcode === fc, rq, "fcode", 64'(rsp_fcode), 64'(fc));
    chk(rsp_paddr === pa, rq, "paddr", 64'(rsp_paddr), 64'(pa));
    if (chk_attr)
      chk({rsp_global, rsp_uncache, rsp_pat} === attr, rq, "attributes",
          64'({rsp_global, rsp_uncache, rsp_pat}), 64'(attr));
  endtask

  task automatic pulse_flush(input bit all, input logic [31:0] va);
    inval_all = all; demap_en = !all; demap_vaddr = va;
    @(negedge clk);
    inval_all = 1'b0; demap_en = 1'b0;
  endtask

  function automatic logic [31:0] lpage(input int i);
    return 32'h1000_0000 + 32'(i) * 32'h1000;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit wk;
    rst_n = 1'b0;
    req_valid = 0; req_vaddr = '0; req_write = 0; req_exec = 0; req_user = 0;
    req_touch = 0; walk_done = 0; walk_fault = 0; walk_fcode = '0;
    walk_pbase = '0; walk_size = '0; walk_wr = 0; walk_usr = 0; walk_nx = 0;
    walk_glb = 0; walk_uc = 0; walk_pat = 0;
    inval_all = 0; demap_en = 0; demap_vaddr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1 && rsp_valid === 1'b0 && walk_req === 1'b0,
        "R3", "reset state", 64'({req_ready, rsp_valid, walk_req}), 64'b100);

    // Priming walks for the three page sizes (R2, R4).
    xlate(32'h0041_2345, 0, 0, 1, 1, wk);
    chk(wk, "R4", "4M page walked", 64'(wk), 64'd1);
    expect_rsp("R4", 2'd0, 4'h0, 40'h00_C001_2345, 3'b000, 1);
    xlate(32'h0081_0ABC, 0, 0, 1, 1, wk);
    chk(wk, "R4", "2M page walked", 64'(wk), 64'd1);
    expect_rsp("R2", 2'd0, 4'h0, 40'h01_0021_0ABC, 3'b011, 1);
    xlate(32'h1234_5678, 1, 0, 0, 1, wk);
    chk(wk, "R4", "4K page walked", 64'(wk), 64'd1);
    expect_rsp("R2", 2'd0, 4'h0, 40'h50_0234_5678, 3'b100, 1);

    // Hit table: R1 merges and R6 protection on hits.
    for (int k = 0; k < 8; k++) begin
      xlate(VT[k].va, VT[k].w, VT[k].x, VT[k].u, 1, wk);
      chk(!wk, "R1", "table row hits", 64'(wk), 64'd0);
      expect_rsp(VT[k].st == 2'd0 ? "R1" : "R6", VT[k].st, VT[k].fc, VT[k].pa,
                 VT[k].attr, VT[k].st == 2'd0);
    end

    // R5: walker faults pass through and install nothing.
    xlate(32'hF000_7000, 0, 0, 0, 1, wk);
    expect_rsp("R5", 2'd1, 4'h7, 40'h0, 3'b000, 0);
    xlate(32'hF000_7000, 0, 0, 0, 1, wk);
    chk(wk, "R5", "fault not cached", 64'(wk), 64'd1);
    xlate(32'h2000_0000, 0, 1, 0, 1, wk);
    expect_rsp("R5", 2'd1, 4'hE, 40'h0, 3'b000, 0);

    // R6: protection checked on the rerun after a walk.
    xlate(32'h1777_0000, 0, 0, 1, 1, wk);
    chk(wk, "R6", "walked", 64'(wk), 64'd1);
    expect_rsp("R6", 2'd2, 4'h2, 40'h0, 3'b000, 0);

    // R10: demap by an address anywhere in the 2M page.
    pulse_flush(0, 32'h0081_FFFF);
    xlate(32'h0041_2345, 0, 0, 1, 1, wk);
    chk(!wk, "R10", "4M page kept", 64'(wk), 64'd0);
    xlate(32'h1234_5678, 0, 0, 0, 1, wk);
    chk(!wk, "R10", "4K page kept", 64'(wk), 64'd0);
    xlate(32'h0081_0ABC, 0, 0, 1, 1, wk);
    chk(wk, "R10", "2M page removed", 64'(wk), 64'd1);
    expect_rsp("R10", 2'd0, 4'h0, 40'h01_0021_0ABC, 3'b011, 1);

    // R9: flush everything.
    pulse_flush(1, 32'h0);
    xlate(32'h0041_2345, 0, 0, 1, 1, wk);
    chk(wk, "R9", "4M page gone", 64'(wk), 64'd1);
    xlate(32'h1234_5678, 0, 0, 0, 1, wk);
    chk(wk, "R9", "4K page gone", 64'(wk), 64'd1);

    // R7 / R8: recency order observed through later misses.
    pulse_flush(1, 32'h0);
    for (int i = 0; i < 16; i++) xlate(lpage(i), 0, 0, 0, 1, wk);
    xlate(lpage(0), 0, 0, 0, 1, wk);
    chk(!wk, "R8", "page 0 hit", 64'(wk), 64'd0);
    xlate(lpage(16), 0, 0, 0, 1, wk);
    xlate(lpage(0), 0, 0, 0, 0, wk);
    chk(!wk, "R8", "promoted page 0 kept", 64'(wk), 64'd0);
    xlate(lpage(1), 0, 0, 0, 1, wk);
    chk(wk, "R7", "oldest page 1 evicted", 64'(wk), 64'd1);
    xlate(lpage(3), 0, 0, 0, 0, wk);
    chk(!wk, "R8", "page 3 hit", 64'(wk), 64'd0);
    xlate(lpage(17), 0, 0, 0, 1, wk);
    xlate(lpage(3), 0, 0, 0, 1, wk);
    chk(wk, "R8", "unpromoted page 3 evicted", 64'(wk), 64'd1);
    expect_rsp("R7", 2'd0, 4'h0, 40'h50_0000_3000, 3'b100, 1);
    pulse_flush(0, lpage(9) + 32'h0ABC);
    xlate(lpage(18), 0, 0, 0, 1, wk);
    xlate(lpage(5), 0, 0, 0, 0, wk);
    chk(!wk, "R7", "free slot used before LRU victim", 64'(wk), 64'd0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule